// File: doc/BRIEF.md
# Paper Tape Line-to-Word Assembler

This block accepts one 8-channel paper-tape line per valid beat and turns the stream into host data. It has two modes, selected by a level input. In character mode every line is handed on whole, as an 8-bit character. In binary mode only lines that carry a marker hole in the top channel count as data. The low six channels of three such lines are packed into one 18-bit word, with the first line at the most significant end. Unmarked lines in binary mode are treated as leader or blank tape and are dropped.

The input has no back-pressure. The assembler takes a line on every cycle that the valid input is high, which easily covers a reader that moves a few hundred lines per second. Results leave through a single valid/ready holding stage with a flag that tells words from characters. If a new result completes while the held one has not been taken, the new result replaces it and a sticky overrun flag is raised. A synchronous clear input or any change of mode throws away a partly built word.

Top module: `tape_word_assembler`

## Requirements
- R1: After reset `out_valid` and `overrun` are 0.
- R2: With `bin_mode` = 0, each accepted line appears on the next cycle with `out_valid` = 1, all 8 bits in `out_data[7:0]`, `out_data[17:8]` = 0 and `out_is_word` = 0.
- R3: With `bin_mode` = 1, a line whose bit 7 is 0 is ignored: it adds no frame to the word and produces no output.
- R4: With `bin_mode` = 1, bits [5:0] of three marked lines form one word: the first line goes to `out_data[17:12]`, the second to [11:6] and the third to [5:0]. Bit 6 is ignored. The word appears the cycle after the third line, with `out_is_word` = 1.
- R5: A held result stays valid and unchanged until a cycle with `out_ready` = 1. After that cycle `out_valid` drops unless a new result arrives in the same cycle.
- R6: The block accepts one line on every clock cycle without stalling. With `out_ready` held high, consecutive character lines come out on consecutive cycles.
- R7: `clr` discards any partial word and sets the frame count to zero. A line presented in the same cycle is discarded.
- R8: A change of `bin_mode` discards any partial word in the same way. A line presented in the cycle the change is first seen is discarded.
- R9: A result that completes while a held result is valid and `out_ready` = 0 replaces the held result and sets `overrun`. `overrun` stays 1 until a cycle with `ovr_clear` = 1, and a new overrun event wins over a clear in the same cycle.
- R10: If the held result is taken in the same cycle that a new result completes, `overrun` does not change and the new result becomes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Discard the partial word |
| bin_mode | input | 1 | 1 = binary word packing, 0 = character mode |
| line_valid | input | 1 | A tape line is present this cycle |
| line_data | input | 8 | Tape line, bit 7 is the marker channel |
| out_ready | input | 1 | Host takes the held result |
| ovr_clear | input | 1 | Clear the sticky overrun flag |
| out_valid | output | 1 | A result is held |
| out_data | output | 18 | Word, or character zero-extended |
| out_is_word | output | 1 | 1 = word, 0 = character |
| overrun | output | 1 | Sticky flag: a result was overwritten |

## Verification
The bench builds the block with its default values: 8-bit lines, 6-bit frames, three frames per word and the marker in bit 7. These values give 18-bit words whose three fields can be checked with distinct patterns. Bit 6 is set in some data lines, so a packer that leaks that bit into the word would be caught. Clear and mode changes are applied after one and after two frames, and overrun is driven both with and without a take in the same cycle.

// File: rtl/tape_pkg.sv
package tape_pkg;
  typedef enum logic {ITEM_CHAR = 1'b0, ITEM_WORD = 1'b1} item_kind_e;

  function automatic logic line_counts(input logic bin, input logic mark);
    return bin ? mark : 1'b1;
  endfunction
endpackage

// File: rtl/tape_line_filter.sv
module tape_line_filter #(
  parameter int LINE_W   = 8,
  parameter int MARK_BIT = 7
) (
  input  logic              bin_mode,
  input  logic              flush,
  input  logic              line_valid,
  input  logic [LINE_W-1:0] line_data,
  output logic              take_char,
  output logic              take_frame
);
  import tape_pkg::*;
  logic usable;

  always_comb begin
    usable     = line_valid && !flush && line_counts(bin_mode, line_data[MARK_BIT]);
    take_char  = usable && !bin_mode;
    take_frame = usable && bin_mode;
  end
endmodule

// File: rtl/tape_frame_packer.sv
module tape_frame_packer #(
  parameter int FRAME_W = 6,
  parameter int FRAMES  = 3,
  localparam int WORD_W = FRAME_W * FRAMES,
  localparam int ACC_W  = FRAME_W * (FRAMES - 1),
  localparam int CNT_W  = (FRAMES > 2) ? $clog2(FRAMES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               take_frame,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               word_done,
  output logic [WORD_W-1:0]  word_out,
  output logic [CNT_W-1:0]   frame_cnt
);
  logic [ACC_W-1:0] acc_q;
  logic             last_frame;

  function automatic logic [ACC_W-1:0] shift_in(input logic [ACC_W-1:0] acc,
                                                input logic [FRAME_W-1:0] f);
    logic [ACC_W+FRAME_W-1:0] wide;
    wide = {acc, f};
    return wide[ACC_W-1:0];
  endfunction

  always_comb begin
    last_frame = (frame_cnt == CNT_W'(FRAMES - 1));
    word_done  = take_frame && last_frame;
    word_out   = {acc_q, frame_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_cnt <= '0;
      acc_q     <= '0;
    end else if (flush) begin
      frame_cnt <= '0;
      acc_q     <= '0;
    end else if (take_frame) begin
      if (last_frame) begin
        frame_cnt <= '0;
        acc_q     <= '0;
      end else begin
        frame_cnt <= frame_cnt + CNT_W'(1);
        acc_q     <= shift_in(acc_q, frame_in);
      end
    end
  end
endmodule

// File: rtl/tape_out_stage.sv
module tape_out_stage #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  tape_pkg::item_kind_e push_kind,
  input  logic              out_ready,
  input  logic              ovr_clear,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_is_word,
  output logic              overrun,
  output logic              ovr_event
);
  import tape_pkg::*;

  always_comb ovr_event = push && out_valid && !out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_is_word <= 1'b0;
    end else if (push) begin
      out_valid   <= 1'b1;
      out_data    <= push_data;
      out_is_word <= (push_kind == ITEM_WORD);
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         overrun <= 1'b0;
    else if (ovr_event) overrun <= 1'b1;
    else if (ovr_clear) overrun <= 1'b0;
  end
endmodule

// File: rtl/tape_word_assembler.sv
module tape_word_assembler #(
  parameter int LINE_W   = 8,
  parameter int FRAME_W  = 6,
  parameter int FRAMES   = 3,
  parameter int MARK_BIT = 7,
  localparam int WORD_W  = FRAME_W * FRAMES,
  localparam int CNT_W   = (FRAMES > 2) ? $clog2(FRAMES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bin_mode,
  input  logic              line_valid,
  input  logic [LINE_W-1:0] line_data,
  input  logic              out_ready,
  input  logic              ovr_clear,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_is_word,
  output logic              overrun
);
  import tape_pkg::*;

  logic              mode_q;
  logic              mode_chg;
  logic              flush;
  logic              take_char;
  logic              take_frame;
  logic              word_done;
  logic [WORD_W-1:0] word_val;
  logic [CNT_W-1:0]  frame_cnt;
  logic              item_push;
  logic [WORD_W-1:0] item_data;
  item_kind_e        item_kind;
  logic              ovr_event;

  function automatic logic [WORD_W-1:0] widen_char(input logic [LINE_W-1:0] c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LINE_W-1:0] = c;
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= bin_mode;
  end

  always_comb begin
    mode_chg  = (bin_mode != mode_q);
    flush     = clr || mode_chg;
    item_push = take_char || word_done;
    item_kind = take_char ? ITEM_CHAR : ITEM_WORD;
    item_data = take_char ? widen_char(line_data) : word_val;
  end

  tape_line_filter #(.LINE_W(LINE_W), .MARK_BIT(MARK_BIT)) u_filter (
    .bin_mode  (bin_mode),
    .flush     (flush),
    .line_valid(line_valid),
    .line_data (line_data),
    .take_char (take_char),
    .take_frame(take_frame)
  );

  tape_frame_packer #(.FRAME_W(FRAME_W), .FRAMES(FRAMES)) u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .take_frame(take_frame),
    .frame_in  (line_data[FRAME_W-1:0]),
    .word_done (word_done),
    .word_out  (word_val),
    .frame_cnt (frame_cnt)
  );

  tape_out_stage #(.DATA_W(WORD_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (item_push),
    .push_data  (item_data),
    .push_kind  (item_kind),
    .out_ready  (out_ready),
    .ovr_clear  (ovr_clear),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_is_word(out_is_word),
    .overrun    (overrun),
    .ovr_event  (ovr_event)
  );
endmodule

// File: rtl/tape_word_assembler_chk.sv
module tape_word_assembler_chk #(
  parameter int LINE_W   = 8,
  parameter int WORD_W   = 18,
  parameter int FRAMES   = 3,
  parameter int CNT_W    = 2,
  parameter int MARK_BIT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bin_mode,
  input logic              line_valid,
  input logic [LINE_W-1:0] line_data,
  input logic              out_ready,
  input logic              ovr_clear,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_data,
  input logic              out_is_word,
  input logic              overrun,
  input logic              flush,
  input logic              item_push,
  input logic [CNT_W-1:0]  frame_cnt
);
  assert_char_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_word |-> out_data[WORD_W-1:LINE_W] == '0);

  assert_unmarked_skipped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid && bin_mode && !line_data[MARK_BIT] |-> !item_push);

  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt < CNT_W'(FRAMES));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !item_push |=> out_valid && $stable(out_data) && $stable(out_is_word));

  assert_flush_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> frame_cnt == '0);

  assert_overrun_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    item_push && out_valid && !out_ready |=> overrun);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clear |=> overrun);

  assert_take_no_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !overrun && (!item_push || !out_valid || out_ready) |=> !overrun);
endmodule

bind tape_word_assembler tape_word_assembler_chk #(
  .LINE_W(LINE_W), .WORD_W(WORD_W), .FRAMES(FRAMES), .CNT_W(CNT_W), .MARK_BIT(MARK_BIT)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bin_mode   (bin_mode),
  .line_valid (line_valid),
  .line_data  (line_data),
  .out_ready  (out_ready),
  .ovr_clear  (ovr_clear),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_is_word(out_is_word),
  .overrun    (overrun),
  .flush      (flush),
  .item_push  (item_push),
  .frame_cnt  (frame_cnt)
);

// File: tb/test_tape_word_assembler.sv
module test_tape_word_assembler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        bin_mode = 1'b0;
  logic        line_valid = 1'b0;
  logic [7:0]  line_data = 8'h00;
  logic        out_ready = 1'b0;
  logic        ovr_clear = 1'b0;
  logic        out_valid;
  logic [17:0] out_data;
  logic        out_is_word;
  logic        overrun;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tape_word_assembler i_tape_word_assembler (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bin_mode(bin_mode),
    .line_valid(line_valid), .line_data(line_data),
    .out_ready(out_ready), .ovr_clear(ovr_clear),
    .out_valid(out_valid), .out_data(out_data),
    .out_is_word(out_is_word), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected word from three frames, first frame most significant.
  function automatic logic [17:0] pack3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    return (18'(a & 8'h3F) << 12) | (18'(b & 8'h3F) << 6) | 18'(c & 8'h3F);
  endfunction

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    line_valid = 1'b1;
    line_data  = d;
    @(negedge clk);
    line_valid = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    bin_mode = m;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 overrun", 32'(overrun), 32'd0);
  endtask

  task automatic t_alpha();
    logic [7:0] pat [3] = '{8'hA5, 8'h00, 8'hFF};
    foreach (pat[i]) begin
      send(pat[i]);
      chk("R2 valid", 32'(out_valid), 32'd1);
      chk("R2 data", 32'(out_data), 32'(pat[i]));
      chk("R2 kind", 32'(out_is_word), 32'd0);
      take();
      chk("R5 valid drops after take", 32'(out_valid), 32'd0);
    end
  endtask

  task automatic t_hold();
    send(8'h5A);
    repeat (3) @(negedge clk);
    chk("R5 still valid", 32'(out_valid), 32'd1);
    chk("R5 data held", 32'(out_data), 32'h5A);
    take();
    chk("R5 valid drops", 32'(out_valid), 32'd0);
  endtask

  task automatic t_binary();
    set_mode(1'b1);
    send(8'hC1);
    send(8'h00);
    send(8'h92);
    send(8'h3F);
    chk("R3 no output from partial or unmarked", 32'(out_valid), 32'd0);
    send(8'hBF);
    chk("R4 valid", 32'(out_valid), 32'd1);
    chk("R4 word", 32'(out_data), 32'(pack3(8'hC1, 8'h92, 8'hBF)));
    chk("R4 kind", 32'(out_is_word), 32'd1);
    take();
    send(8'h7F);
    send(8'h7F);
    send(8'h7F);
    chk("R3 unmarked lines ignored", 32'(out_valid), 32'd0);
    send(8'h80); send(8'hFF); send(8'hAA);
    chk("R3 word unaffected by skipped lines", 32'(out_data), 32'(pack3(8'h80, 8'hFF, 8'hAA)));
    take();
  endtask

  task automatic t_burst();
    set_mode(1'b0);
    @(negedge clk);
    out_ready  = 1'b1;
    line_valid = 1'b1;
    line_data  = 8'h30;
    for (int i = 1; i < 6; i++) begin
      @(negedge clk);
      chk("R6 back-to-back valid", 32'(out_valid), 32'd1);
      chk("R6 back-to-back data", 32'(out_data), 32'(8'h30 + i - 1));
      line_data = 8'(8'h30 + i);
    end
    @(negedge clk);
    line_valid = 1'b0;
    chk("R6 last data", 32'(out_data), 32'h35);
    chk("R10 no overrun in burst", 32'(overrun), 32'd0);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R5 drained", 32'(out_valid), 32'd0);
  endtask

  task automatic t_clear();
    set_mode(1'b1);
    send(8'h81); send(8'h82);
    @(negedge clk);
    clr = 1'b1; line_valid = 1'b1; line_data = 8'h83;
    @(negedge clk);
    clr = 1'b0; line_valid = 1'b0;
    chk("R7 nothing out after clear", 32'(out_valid), 32'd0);
    send(8'h84); send(8'h85);
    chk("R7 count restarted", 32'(out_valid), 32'd0);
    send(8'h86);
    chk("R7 word after clear", 32'(out_data), 32'(pack3(8'h84, 8'h85, 8'h86)));
    take();
  endtask

  task automatic t_mode();
    send(8'hA1);
    @(negedge clk);
    bin_mode = 1'b0; line_valid = 1'b1; line_data = 8'h41;
    @(negedge clk);
    line_valid = 1'b0;
    chk("R8 line dropped on mode change", 32'(out_valid), 32'd0);
    send(8'h42);
    chk("R8 char mode after change", 32'(out_data), 32'h42);
    chk("R8 kind char", 32'(out_is_word), 32'd0);
    take();
    set_mode(1'b1);
    send(8'hB1); send(8'hB2);
    chk("R8 partial discarded", 32'(out_valid), 32'd0);
    send(8'hB3);
    chk("R8 word after mode return", 32'(out_data), 32'(pack3(8'hB1, 8'hB2, 8'hB3)));
    take();
  endtask

  task automatic t_overrun();
    set_mode(1'b0);
    send(8'h11);
    send(8'h22);
    chk("R9 overrun set", 32'(overrun), 32'd1);
    chk("R9 newest kept", 32'(out_data), 32'h22);
    repeat (2) @(negedge clk);
    chk("R9 sticky", 32'(overrun), 32'd1);
    take();
    chk("R9 sticky after take", 32'(overrun), 32'd1);
    @(negedge clk);
    ovr_clear = 1'b1;
    @(negedge clk);
    ovr_clear = 1'b0;
    chk("R9 cleared", 32'(overrun), 32'd0);
  endtask

  task automatic t_simul();
    send(8'h33);
    @(negedge clk);
    out_ready = 1'b1; line_valid = 1'b1; line_data = 8'h44;
    @(negedge clk);
    out_ready = 1'b0; line_valid = 1'b0;
    chk("R10 no overrun", 32'(overrun), 32'd0);
    chk("R10 new valid", 32'(out_valid), 32'd1);
    chk("R10 new data", 32'(out_data), 32'h44);
    take();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alpha();
    t_hold();
    t_binary();
    t_burst();
    t_clear();
    t_mode();
    t_overrun();
    t_simul();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule